// File: doc/BRIEF.md
# Continuous audio DMA engine

A free-running engine that moves audio one bit at a time between system memory and a pair of serial audio lines. An output buffer is read bit by bit, most significant bit of each byte first, and shifted onto the serial output. The serial input is written bit by bit into an input buffer. Both buffers share one length, given in eight-byte units. When the last bit of the buffer has moved, both positions return to their base addresses and the engine carries on without software help.

Software controls the engine through a small register window of 16-bit halfwords. The window repeats every 32 bytes of the address space. A 16-bit control register holds separate input and output enables, an output unmute bit, a pass-through bit and a two-bit rate choice. A read-only counter gives the number of bits left before the buffer wraps. Two read-only status registers return fixed values. The memory side has a byte read port with a same-cycle answer and a single-bit write port.

Register halfwords, indexed by address bits [4:1] with everything above bit 4 ignored: 0 control, 1 control alias, 2 and 3 status word low and high halves, 4 bits-left counter, 6 and 7 input base low and high, 8 and 9 output base low and high, 10 length, 11 short status. All other indices read as zero.

Top module: `audma_engine`

## Requirements
- R1: After reset the control register, the bits-left counter and `ser_out` read 0, and `mem_wr_en` stays low.
- R2: The register window repeats every 32 bytes. A write to halfword index 1 updates the control register just as a write to index 0 does.
- R3: Index 2 reads 0x0002, index 3 reads 0x0040 and index 11 reads 0x0200. Writes to these indices and to the counter (index 4) leave every read value unchanged.
- R4: When control bit 7 (input enable) or bit 8 (output enable) is set while the engine is idle, the counter loads length×64 on the next clock. Each bit transfer after that lowers it by one.
- R5: The control bits {11,9} pick the clocks per bit: 10 and 11 give DIV_FAST, 01 gives DIV_MID, and 00 gives DIV_SLOW.
- R6: With bit 8 and bit 2 set and bit 6 clear, each transfer takes bit 7−(p mod 8) of the byte at output base + p/8, where p is the bit position. That bit appears on `ser_out` one clock after the transfer.
- R7: With bit 8 set and bit 2 clear, `ser_out` is 0 after every transfer.
- R8: With bit 7 set, each transfer writes `ser_in` to bit 7−(p mod 8) of the byte at input base + p/8. With bit 7 clear, nothing is written.
- R9: With bits 8, 2 and 6 set, `ser_out` carries the `ser_in` value sampled at the transfer instead of buffer data.
- R10: The transfer that brings the counter from 1 to the end returns the bit position to 0 and reloads the counter with length×64.
- R11: Once bits 7 and 8 are both clear, the next clock stops all transfers and clears the counter. `ser_out` reads 0 while bit 8 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write qualifier for the strobe |
| reg_addr | input | REG_AW | Byte address of the halfword |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| mem_rd_addr | output | ADDR_W | Byte address of the current output-buffer byte |
| mem_rd_data | input | 8 | Byte at mem_rd_addr, same cycle |
| mem_wr_en | output | 1 | Input-buffer bit write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the bit written |
| mem_wr_bit | output | 3 | Bit index within that byte |
| mem_wr_val | output | 1 | Bit value written |
| ser_in | input | 1 | Serial audio in |
| ser_out | output | 1 | Serial audio out (registered) |

## Verification
On every cycle the assertions check the step-by-step laws: the counter falls by one per transfer, it reloads and the position returns to zero at the end of the buffer, no two transfers occur back to back, muted output stays low, pass-through copies the sampled input, and no write happens without the input enable. The exact rate spacing, the bit order read from memory, the bytes that end up in the input buffer, the mirrored and aliased register decode and the fixed status values are shown only by the bench scenarios. These scenarios are compared against a behavioural model on every clock.

// File: rtl/audma_pkg.sv
package audma_pkg;
    // control register bit positions
    localparam int CB_UNMUTE  = 2;
    localparam int CB_PASS    = 6;
    localparam int CB_IN      = 7;
    localparam int CB_OUT     = 8;
    localparam int CB_RATE_LO = 9;
    localparam int CB_RATE_HI = 11;

    // halfword indices inside the 32-byte window
    localparam logic [3:0] IX_CTRL   = 4'd0;
    localparam logic [3:0] IX_CTRL_A = 4'd1;
    localparam logic [3:0] IX_STW_LO = 4'd2;
    localparam logic [3:0] IX_STW_HI = 4'd3;
    localparam logic [3:0] IX_LEFT   = 4'd4;
    localparam logic [3:0] IX_INB_LO = 4'd6;
    localparam logic [3:0] IX_INB_HI = 4'd7;
    localparam logic [3:0] IX_OUB_LO = 4'd8;
    localparam logic [3:0] IX_OUB_HI = 4'd9;
    localparam logic [3:0] IX_LEN    = 4'd10;
    localparam logic [3:0] IX_STH    = 4'd11;

    // fixed read-back values
    localparam logic [15:0] STW_LO_VAL = 16'h0002;
    localparam logic [15:0] STW_HI_VAL = 16'h0040;
    localparam logic [15:0] STH_VAL    = 16'h0200;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_FAST = 2'b10,
        RATE_ALT  = 2'b11
    } rate_e;
endpackage

// File: rtl/audma_regs.sv
module audma_regs
    import audma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic [15:0]       left_i,
    output logic [15:0]       reg_rdata,
    output logic [15:0]       ctrl_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] inb_o,
    output logic [ADDR_W-1:0] outb_o
);
    typedef struct packed {
        logic [15:0]       ctrl;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] inb;
        logic [ADDR_W-1:0] outb;
    } regs_t;

    regs_t       regs_d, regs_q;
    logic [3:0]  idx;
    logic [31:0] inb_w, outb_w;
    logic        unused_addr_bits;

    // only bits [4:1] decode: the window repeats every 32 bytes
    assign idx              = reg_addr[4:1];
    assign unused_addr_bits = ^{reg_addr[REG_AW-1:5], reg_addr[0]};
    assign inb_w            = 32'(regs_q.inb);
    assign outb_w           = 32'(regs_q.outb);

    always_comb begin
        regs_d = regs_q;
        if (reg_sel && reg_wr) begin
            case (idx)
                IX_CTRL, IX_CTRL_A: regs_d.ctrl = reg_wdata;
                IX_INB_LO: regs_d.inb  = ADDR_W'({inb_w[31:16], reg_wdata});
                IX_INB_HI: regs_d.inb  = ADDR_W'({reg_wdata, inb_w[15:0]});
                IX_OUB_LO: regs_d.outb = ADDR_W'({outb_w[31:16], reg_wdata});
                IX_OUB_HI: regs_d.outb = ADDR_W'({reg_wdata, outb_w[15:0]});
                IX_LEN:    regs_d.len  = LEN_W'(reg_wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (idx)
            IX_CTRL, IX_CTRL_A: reg_rdata = regs_q.ctrl;
            IX_STW_LO:          reg_rdata = STW_LO_VAL;
            IX_STW_HI:          reg_rdata = STW_HI_VAL;
            IX_LEFT:            reg_rdata = left_i;
            IX_INB_LO:          reg_rdata = inb_w[15:0];
            IX_INB_HI:          reg_rdata = inb_w[31:16];
            IX_OUB_LO:          reg_rdata = outb_w[15:0];
            IX_OUB_HI:          reg_rdata = outb_w[31:16];
            IX_LEN:             reg_rdata = 16'(regs_q.len);
            IX_STH:             reg_rdata = STH_VAL;
            default:            reg_rdata = 16'h0000;
        endcase
    end

    assign ctrl_o = regs_q.ctrl;
    assign len_o  = regs_q.len;
    assign inb_o  = regs_q.inb;
    assign outb_o = regs_q.outb;
endmodule

// File: rtl/audma_rate.sv
module audma_rate
    import audma_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    localparam int MAX_AB = (DIV_FAST > DIV_MID) ? DIV_FAST : DIV_MID;
    localparam int MAX_D  = (MAX_AB > DIV_SLOW) ? MAX_AB : DIV_SLOW;
    localparam int DIV_W  = $clog2(MAX_D + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } rate_t;

    rate_t            st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        case (rate_e'(rate_i))
            RATE_MID:  lim = DIV_W'(DIV_MID);
            RATE_SLOW: lim = DIV_W'(DIV_SLOW);
            default:   lim = DIV_W'(DIV_FAST);
        endcase
    end

    // ">=" lets a rate change in mid-stream fall straight onto the new limit
    assign tick_o = run_i && (st_q.div >= lim - DIV_W'(1));

    always_comb begin
        st_d = st_q;
        if (!run_i || tick_o) st_d.div = '0;
        else                  st_d.div = st_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/audma_stream.sv
module audma_stream #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = LEN_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en_i,
    input  logic              out_en_i,
    input  logic              unmute_i,
    input  logic              pass_i,
    input  logic              tick_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] inb_i,
    input  logic [ADDR_W-1:0] outb_i,
    input  logic              ser_in,
    input  logic [7:0]        mem_rd_data,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [2:0]        mem_wr_bit,
    output logic              mem_wr_val,
    output logic              ser_out,
    output logic              run_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  pos_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pos;
        logic             sout;
    } strm_t;

    strm_t             st_d, st_q;
    logic              any_en;
    logic              xfer;
    logic              rd_bit;
    logic [CNT_W-1:0]  reload;
    logic [ADDR_W-1:0] byte_off;
    logic [2:0]        bit_sel;

    assign any_en   = in_en_i | out_en_i;
    assign xfer     = tick_i && (st_q.cnt != '0);
    assign reload   = CNT_W'(len_i) << 6;
    assign byte_off = ADDR_W'(st_q.pos >> 3);
    assign bit_sel  = 3'd7 - st_q.pos[2:0];
    assign rd_bit   = mem_rd_data[bit_sel];

    always_comb begin
        st_d = st_q;
        if (!any_en) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.pos = '0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = reload;
            st_d.pos = '0;
        end else if (xfer) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.cnt = reload;
                st_d.pos = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                st_d.pos = st_q.pos + CNT_W'(1);
            end
        end

        if (!out_en_i)     st_d.sout = 1'b0;
        else if (xfer)     st_d.sout = !unmute_i ? 1'b0 : (pass_i ? ser_in : rd_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_rd_addr = outb_i + byte_off;
    assign mem_wr_en   = xfer && in_en_i;
    assign mem_wr_addr = inb_i + byte_off;
    assign mem_wr_bit  = bit_sel;
    assign mem_wr_val  = ser_in;
    assign ser_out     = st_q.sout;
    assign run_o       = st_q.run;
    assign cnt_o       = st_q.cnt;
    assign pos_o       = st_q.pos;
endmodule

// File: rtl/audma_engine.sv
module audma_engine
    import audma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int REG_AW   = 12,
    parameter int LEN_W    = 16,
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [2:0]        mem_wr_bit,
    output logic              mem_wr_val,
    input  logic              ser_in,
    output logic              ser_out
);
    localparam int CNT_W = LEN_W + 6;

    logic [15:0]       ctrl_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] inb_q, outb_q;
    logic [CNT_W-1:0]  cnt_q, pos_q;
    logic              run_q;
    logic              tick;
    logic              unused_ctrl;

    assign unused_ctrl = ^{ctrl_q[15:12], ctrl_q[10], ctrl_q[5:3], ctrl_q[1:0],
                           cnt_q[CNT_W-1:16]};

    audma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_AW(REG_AW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .left_i    (cnt_q[15:0]),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl_q),
        .len_o     (len_q),
        .inb_o     (inb_q),
        .outb_o    (outb_q)
    );

    audma_rate #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_q && (ctrl_q[CB_IN] || ctrl_q[CB_OUT])),
        .rate_i ({ctrl_q[CB_RATE_HI], ctrl_q[CB_RATE_LO]}),
        .tick_o (tick)
    );

    audma_stream #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_en_i     (ctrl_q[CB_IN]),
        .out_en_i    (ctrl_q[CB_OUT]),
        .unmute_i    (ctrl_q[CB_UNMUTE]),
        .pass_i      (ctrl_q[CB_PASS]),
        .tick_i      (tick),
        .len_i       (len_q),
        .inb_i       (inb_q),
        .outb_i      (outb_q),
        .ser_in      (ser_in),
        .mem_rd_data (mem_rd_data),
        .mem_rd_addr (mem_rd_addr),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_bit  (mem_wr_bit),
        .mem_wr_val  (mem_wr_val),
        .ser_out     (ser_out),
        .run_o       (run_q),
        .cnt_o       (cnt_q),
        .pos_o       (pos_q)
    );
endmodule

// File: rtl/audma_engine_chk.sv
module audma_engine_chk #(
    parameter int LEN_W = 16,
    parameter int CNT_W = LEN_W + 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      ctrl,
    input logic [LEN_W-1:0] len,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] pos,
    input logic             tick,
    input logic             mem_wr_en,
    input logic             ser_in,
    input logic             ser_out
);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_mute_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0 && ctrl[8] && !ctrl[2]) |=> !ser_out);

    assert_write_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ctrl[7]);

    assert_pass_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0 && ctrl[8] && ctrl[2] && ctrl[6]) |=> (ser_out == $past(ser_in)));

    assert_wrap_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == CNT_W'(1)) |=> (pos == '0 && cnt == (CNT_W'($past(len)) << 6)));

    assert_stop_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[7] && !ctrl[8]) |=> (cnt == '0 && !mem_wr_en));
endmodule

bind audma_engine audma_engine_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl_q),
    .len       (len_q),
    .cnt       (cnt_q),
    .pos       (pos_q),
    .tick      (tick),
    .mem_wr_en (mem_wr_en),
    .ser_in    (ser_in),
    .ser_out   (ser_out)
);

// File: tb/test_audma_engine.sv
`timescale 1ns/1ps
module test_audma_engine;
    localparam int DF = 4, DM = 8, DS = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h008;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en, mem_wr_val, ser_out;
    logic [2:0]  mem_wr_bit;
    logic        ser_in = 1'b0;
    logic [7:0]  lfsr = 8'h5B;

    int checks = 0, fails = 0, cyc = 0, wrap_hits = 0;
    logic [7:0] mem [0:255];

    always #2 clk = ~clk;

    audma_engine #(.DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS)) i_audma_engine (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_bit(mem_wr_bit),
        .mem_wr_val(mem_wr_val), .ser_in(ser_in), .ser_out(ser_out)
    );

    assign mem_rd_data = mem[mem_rd_addr[7:0]];
    always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr[7:0]][mem_wr_bit] <= mem_wr_val;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ser_in <= lfsr[0];
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] m_ctrl;
    logic [31:0] m_inb, m_outb;
    int          m_len, m_div, m_pos, m_cnt;
    bit          m_run, m_out, e_wr;
    logic [7:0]  m_inmem [0:255];

    function automatic int lim_of(input logic [15:0] c);
        if ({c[11], c[9]} == 2'b01) return DM;
        if ({c[11], c[9]} == 2'b00) return DS;
        return DF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_inb = '0; m_outb = '0; m_len = 0;
            m_div = 0; m_pos = 0; m_cnt = 0; m_run = 0; m_out = 0; e_wr = 0;
        end else begin
            bit any, tk, x;
            logic [7:0] b;
            any = m_ctrl[7] | m_ctrl[8];
            tk  = m_run && any && (m_div >= lim_of(m_ctrl) - 1);
            x   = tk && (m_cnt != 0);
            b   = mem[8'(m_outb + 32'(m_pos / 8))];
            if (!m_ctrl[8]) m_out = 0;
            else if (x) m_out = !m_ctrl[2] ? 1'b0 : (m_ctrl[6] ? ser_in : b[7 - m_pos % 8]);
            if (x && m_ctrl[7]) m_inmem[8'(m_inb + 32'(m_pos / 8))][7 - m_pos % 8] = ser_in;
            if (!(m_run && any) || tk) m_div = 0; else m_div++;
            if (!any) begin m_run = 0; m_cnt = 0; m_pos = 0; end
            else if (!m_run) begin m_run = 1; m_cnt = m_len * 64; m_pos = 0; end
            else if (x) begin
                if (m_cnt == 1) begin m_cnt = m_len * 64; m_pos = 0; end
                else begin m_cnt--; m_pos++; end
            end
            if (reg_sel && reg_wr) begin
                case (reg_addr[4:1])
                    4'd0, 4'd1: m_ctrl = reg_wdata;
                    4'd6: m_inb[15:0]   = reg_wdata;
                    4'd7: m_inb[31:16]  = reg_wdata;
                    4'd8: m_outb[15:0]  = reg_wdata;
                    4'd9: m_outb[31:16] = reg_wdata;
                    4'd10: m_len = int'(reg_wdata);
                    default: ;
                endcase
            end
            any  = m_ctrl[7] | m_ctrl[8];
            e_wr = m_run && any && (m_div >= lim_of(m_ctrl) - 1) && m_cnt != 0 && m_ctrl[7];
        end
    end

    // per-clock comparison just after each edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (m_ctrl[6]) check("R9 ser_out", int'(ser_out), int'(m_out));
                else if (!m_ctrl[2]) check("R7 ser_out", int'(ser_out), int'(m_out));
                else check("R6 ser_out", int'(ser_out), int'(m_out));
                check("R8 mem_wr_en", int'(mem_wr_en), int'(e_wr));
                if (e_wr) begin
                    check("R8 wr_addr", int'(mem_wr_addr), int'(m_inb + 32'(m_pos / 8)));
                    check("R8 wr_bit", int'(mem_wr_bit), 7 - m_pos % 8);
                    if (mem_wr_addr == 32'h40 && mem_wr_bit == 3'd7) wrap_hits++;
                end
                if (!reg_sel && reg_addr == 12'h008)
                    check("R4 counter", int'(reg_rdata), m_cnt & 16'hFFFF);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_sel = 0; reg_wr = 0; reg_addr = 12'h008;
    endtask

    task automatic rd(input logic [11:0] a, output int v);
        @(negedge clk); reg_addr = a; #1 v = int'(reg_rdata); reg_addr = 12'h008;
    endtask

    task automatic next_xfer();
        do @(negedge clk); while (!mem_wr_en);
    endtask

    task automatic spacing(input int expv);
        int t0;
        next_xfer(); t0 = cyc;
        next_xfer();
        check("R5 clocks per bit", cyc - t0, expv);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #800000;
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int v;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = (i >= 8'h80 && i < 8'h88) ? 8'(i * 37 + 11) : 8'h00;
            m_inmem[i] = mem[i];
        end
        mem[8'h80] = 8'hA5; m_inmem[8'h80] = 8'hA5;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(12'h000, v); check("R1 ctrl", v, 0);
        rd(12'h008, v); check("R1 counter", v, 0);
        check("R1 ser_out", int'(ser_out), 0);
        check("R1 mem_wr_en", int'(mem_wr_en), 0);
        // R2 mirror and alias
        wr(12'h7A2, 16'h0A00);
        rd(12'h000, v); check("R2 alias write", v, 16'h0A00);
        rd(12'h020, v); check("R2 mirror read", v, 16'h0A00);
        wr(12'h054, 16'h0001);
        rd(12'h014, v); check("R2 mirror len", v, 1);
        // R3 fixed status
        rd(12'h004, v); check("R3 status lo", v, 16'h0002);
        rd(12'h006, v); check("R3 status hi", v, 16'h0040);
        rd(12'h016, v); check("R3 short status", v, 16'h0200);
        wr(12'h016, 16'hFFFF); wr(12'h004, 16'h1234); wr(12'h008, 16'h7777);
        rd(12'h016, v); check("R3 short after write", v, 16'h0200);
        rd(12'h004, v); check("R3 status after write", v, 16'h0002);
        rd(12'h008, v); check("R3 counter after write", v, 0);
        // buffers
        wr(12'h00C, 16'h0040); wr(12'h00E, 16'h0000);
        wr(12'h010, 16'h0080); wr(12'h012, 16'h0000);
        // start: fast rate, in+out, unmuted
        wr(12'h000, 16'h0984);
        rd(12'h008, v); check("R4 load len*64", v, 64);
        next_xfer(); @(posedge clk); #1 check("R6 first bit", int'(ser_out), 1);
        next_xfer(); @(posedge clk); #1 check("R6 second bit", int'(ser_out), 0);
        spacing(DF);
        repeat (300) @(negedge clk);
        check("R10 wrapped to base", int'(wrap_hits >= 2), 1);
        wr(12'h000, 16'h0384); spacing(DM);
        wr(12'h000, 16'h0184); spacing(DS);
        wr(12'h000, 16'h0A84); spacing(DF);
        // R7 mute
        wr(12'h000, 16'h0980);
        repeat (3) next_xfer();
        begin
            int hi = 0;
            for (int i = 0; i < 60; i++) begin @(negedge clk); if (ser_out) hi++; end
            check("R7 muted output", hi, 0);
        end
        // R9 pass-through
        wr(12'h000, 16'h09C4);
        for (int i = 0; i < 6; i++) begin
            logic s;
            next_xfer(); @(posedge clk); s = ser_in; #1;
            check("R9 pass copy", int'(ser_out), int'(s));
        end
        // R11 stop
        wr(12'h000, 16'h0000);
        begin
            int w = 0, o = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk); if (mem_wr_en) w++; if (ser_out) o++;
            end
            check("R11 no writes", w, 0);
            check("R11 output low", o, 0);
        end
        rd(12'h008, v); check("R11 counter cleared", v, 0);
        for (int i = 8'h40; i < 8'h48; i++) check("R8 input buffer", int'(mem[i]), int'(m_inmem[i]));
        finish_run();
    end
endmodule